// File: doc/BRIEF.md
# Line Buffer Serializer

This block stores one scan line of up to 320 sixteen-bit words and then emits that line as one serial bit stream. Words come from a processor or DMA bus, one word per write strobe. A line begins with a line-start pulse, which clears the word count. A send pulse starts transmission of every word written since then. The same stored line can be sent again with another send pulse, and memory does not need to be rewritten.

Several settings are sampled when a send is accepted and hold for the whole line. Word order is either write order or reverse order. Bit order within a word is either most-significant first or least-significant first. An optional prefix of a programmable number of constant bits, all high or all low, can go out ahead of the data. Bits advance in one of two ways. The first is an internal free-running divider, which also drives a bit clock to the receiver. The second is the rising edge of a data-request clock from the receiver. While the line is going out, busy is high. When the last bit has finished, busy drops and an interrupt flag rises.

Top module: `line_serializer`

## Requirements
- R1: After reset, busy_o, irq_o, data_o and ser_clk_o are all 0.
- R2: With cfg_lifo_i=0, words leave in the order they were written (first written word first).
- R3: With cfg_lifo_i=1, words leave in reverse order (last written word first).
- R4: With cfg_lsb_first_i=0, each word goes out from bit 15 down to bit 0. With cfg_lsb_first_i=1, it goes out from bit 0 up to bit 15.
- R5: With cfg_pfx_en_i=1, cfg_pfx_len_i bits at the level of cfg_pfx_level_i go out before the first data bit. A length of 0 sends no prefix.
- R6: A line is exactly prefix length plus 16 times N bits, where N is the number of words written since the last line_start_i. After the last bit, busy_o falls and irq_o rises in the same cycle. irq_o stays high until the next accepted send_i or line_start_i. data_o is 0 whenever busy_o is low.
- R7: In free-running mode (cfg_ext_clk_i=0), ser_clk_o has a period of 2·2^cfg_div_sel_i clk_i cycles, with cfg_div_sel_i limited to 4. It is low for the first half of each bit and high for the second half. data_o changes only on the clock edge where ser_clk_o falls.
- R8: In free-running mode, a cycle with clk_en_i=0 leaves ser_clk_o and data_o unchanged.
- R9: In request mode (cfg_ext_clk_i=1), each rising edge of req_clk_i advances the stream by one bit, and ser_clk_o stays 0.
- R10: A send_i after a finished line, with no new writes, sends the identical bit stream again.
- R11: At most 320 words are stored. Writes beyond the 320th are ignored, and a full line is 5120 data bits.
- R12: While busy_o is high, wr_en_i, line_start_i and send_i have no effect. A send_i with zero words stored leaves busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Begin a new line: clears the word count and the interrupt flag |
| wr_en_i | input | 1 | Write strobe: one word per cycle |
| wr_data_i | input | 16 | Word to store |
| send_i | input | 1 | Start sending the stored line |
| cfg_lifo_i | input | 1 | 1 = reverse word order |
| cfg_lsb_first_i | input | 1 | 1 = least significant bit first |
| cfg_pfx_en_i | input | 1 | Enable the constant prefix |
| cfg_pfx_level_i | input | 1 | Prefix level |
| cfg_pfx_len_i | input | 8 | Prefix length in bits |
| cfg_ext_clk_i | input | 1 | 1 = advance on req_clk_i, 0 = advance on the internal divider |
| cfg_div_sel_i | input | 3 | Divider exponent, 0 to 4 |
| clk_en_i | input | 1 | Shift enable for free-running mode |
| req_clk_i | input | 1 | Data-request clock from the receiver |
| ser_clk_o | output | 1 | Bit clock to the receiver (free-running mode) |
| data_o | output | 1 | Serial data |
| busy_o | output | 1 | High while a line is being sent |
| irq_o | output | 1 | End-of-line flag |

## Verification
busy_o and the first bit on data_o appear one clock after the edge that accepts send_i. In free-running mode, each later bit appears on the edge where ser_clk_o falls. The bench therefore reads data_o at the falling clock edge on which it first sees ser_clk_o high, which is half a bit period after the bit was set up. In request mode, a rising edge of req_clk_i passes through two synchronizer stages and one edge register, so the next bit appears three clocks later. The bench holds each request level for three clocks and reads data_o only after the low phase. Completion is checked at the first falling clock edge after busy_o drops, and irq_o must already be high at that point.

// File: rtl/linesr_pkg.sv
package linesr_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_PREFIX, SQ_DATA} seq_state_e;

  typedef struct packed {
    logic lifo;
    logic lsb_first;
    logic pfx_en;
    logic pfx_level;
    logic ext_clk;
  } ser_cfg_t;
endpackage

// File: rtl/linesr_store.sv
module linesr_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 320,
  parameter int CNT_W  = 9,
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_ok;

  // writes past capacity, or during a send, are dropped
  always_comb wr_ok = !lock_i && !clear_i && wr_en_i && (cnt_q < CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!lock_i && clear_i)  cnt_q <= '0;
    else if (wr_ok)               cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[ADDR_W'(cnt_q)] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign count_o   = cnt_q;
endmodule

// File: rtl/linesr_clkgen.sv
module linesr_clkgen #(
  parameter int DIV_LOG_MAX = 4,
  parameter int DSEL_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ext_i,
  input  logic [DSEL_W-1:0] div_sel_i,
  input  logic              clk_en_i,
  input  logic              req_clk_i,
  output logic              tick_o,
  output logic              ser_clk_o
);
  localparam int CW = DIV_LOG_MAX + 1;

  logic [DSEL_W-1:0]    sel;
  logic [CW-1:0]        half, last, cnt_q;
  logic [SYNC_STAGES:0] req_q;
  logic                 fr_step, req_rise;

  always_comb begin
    sel  = (div_sel_i > DSEL_W'(DIV_LOG_MAX)) ? DSEL_W'(DIV_LOG_MAX) : div_sel_i;
    half = CW'(1) << sel;
    last = CW'((half << 1) - CW'(1));
  end

  // request clock: synchronizer chain plus one stage for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= {req_q[SYNC_STAGES-1:0], req_clk_i};
  end
  assign req_rise = req_q[SYNC_STAGES-1] && !req_q[SYNC_STAGES];

  assign fr_step = run_i && !ext_i && clk_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (fr_step) cnt_q <= (cnt_q == last) ? '0 : cnt_q + CW'(1);
  end

  assign tick_o    = ext_i ? (run_i && req_rise) : (fr_step && (cnt_q == last));
  assign ser_clk_o = run_i && !ext_i && (cnt_q >= half);
endmodule

// File: rtl/linesr_seq.sv
module linesr_seq
  import linesr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 9,
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 4,
  parameter int PFX_W  = 8,
  parameter int DSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic              clear_irq_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  ser_cfg_t          cfg_i,
  input  logic [PFX_W-1:0]  pfx_len_i,
  input  logic [DSEL_W-1:0] div_sel_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              ext_o,
  output logic [DSEL_W-1:0] div_sel_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              data_o
);
  seq_state_e        state_q;
  ser_cfg_t          cfg_q;
  logic [DSEL_W-1:0] div_q;
  logic [CNT_W-1:0]  nwords_q, widx_q, rev_idx;
  logic [PFX_W-1:0]  pcnt_q;
  logic [BIT_W-1:0]  bidx_q, bsel;
  logic              irq_q, start;

  assign start = send_i && (state_q == SQ_IDLE) && (word_cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SQ_IDLE;
      cfg_q    <= '0;
      div_q    <= '0;
      nwords_q <= '0;
      widx_q   <= '0;
      pcnt_q   <= '0;
      bidx_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start) begin
            cfg_q    <= cfg_i;
            div_q    <= div_sel_i;
            nwords_q <= word_cnt_i;
            widx_q   <= '0;
            bidx_q   <= '0;
            irq_q    <= 1'b0;
            if (cfg_i.pfx_en && (pfx_len_i != '0)) begin
              state_q <= SQ_PREFIX;
              pcnt_q  <= pfx_len_i - PFX_W'(1);
            end else begin
              state_q <= SQ_DATA;
            end
          end else if (clear_irq_i) begin
            irq_q <= 1'b0;
          end
        end
        SQ_PREFIX: begin
          if (tick_i) begin
            if (pcnt_q == '0) state_q <= SQ_DATA;
            else              pcnt_q  <= pcnt_q - PFX_W'(1);
          end
        end
        SQ_DATA: begin
          if (tick_i) begin
            if (bidx_q == BIT_W'(WORD_W - 1)) begin
              bidx_q <= '0;
              if (widx_q == nwords_q - CNT_W'(1)) begin
                state_q <= SQ_IDLE;
                irq_q   <= 1'b1;
              end else begin
                widx_q <= widx_q + CNT_W'(1);
              end
            end else begin
              bidx_q <= bidx_q + BIT_W'(1);
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    rev_idx   = nwords_q - CNT_W'(1) - widx_q;
    rd_addr_o = ADDR_W'(cfg_q.lifo ? rev_idx : widx_q);
    bsel      = cfg_q.lsb_first ? bidx_q : BIT_W'(WORD_W - 1) - bidx_q;
    unique case (state_q)
      SQ_PREFIX: data_o = cfg_q.pfx_level;
      SQ_DATA:   data_o = rd_data_i[bsel];
      default:   data_o = 1'b0;
    endcase
  end

  assign busy_o    = (state_q != SQ_IDLE);
  assign irq_o     = irq_q;
  assign ext_o     = cfg_q.ext_clk;
  assign div_sel_o = div_q;
endmodule

// File: rtl/line_serializer.sv
module line_serializer
  import linesr_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int DEPTH       = 320,
  parameter int PFX_W       = 8,
  parameter int DIV_LOG_MAX = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DSEL_W     = $clog2(DIV_LOG_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              send_i,
  input  logic              cfg_lifo_i,
  input  logic              cfg_lsb_first_i,
  input  logic              cfg_pfx_en_i,
  input  logic              cfg_pfx_level_i,
  input  logic [PFX_W-1:0]  cfg_pfx_len_i,
  input  logic              cfg_ext_clk_i,
  input  logic [DSEL_W-1:0] cfg_div_sel_i,
  input  logic              clk_en_i,
  input  logic              req_clk_i,
  output logic              ser_clk_o,
  output logic              data_o,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BIT_W  = $clog2(WORD_W);

  ser_cfg_t          cfg_in;
  logic [CNT_W-1:0]  word_cnt;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic [DSEL_W-1:0] div_sel;
  logic              cfg_ext, tick, busy;

  always_comb begin
    cfg_in.lifo      = cfg_lifo_i;
    cfg_in.lsb_first = cfg_lsb_first_i;
    cfg_in.pfx_en    = cfg_pfx_en_i;
    cfg_in.pfx_level = cfg_pfx_level_i;
    cfg_in.ext_clk   = cfg_ext_clk_i;
  end

  linesr_store #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (busy),
    .clear_i   (line_start_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .count_o   (word_cnt)
  );

  linesr_clkgen #(
    .DIV_LOG_MAX(DIV_LOG_MAX), .DSEL_W(DSEL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .ext_i     (cfg_ext),
    .div_sel_i (div_sel),
    .clk_en_i  (clk_en_i),
    .req_clk_i (req_clk_i),
    .tick_o    (tick),
    .ser_clk_o (ser_clk_o)
  );

  linesr_seq #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .BIT_W(BIT_W), .PFX_W(PFX_W), .DSEL_W(DSEL_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .send_i      (send_i),
    .clear_irq_i (line_start_i),
    .tick_i      (tick),
    .word_cnt_i  (word_cnt),
    .cfg_i       (cfg_in),
    .pfx_len_i   (cfg_pfx_len_i),
    .div_sel_i   (cfg_div_sel_i),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .ext_o       (cfg_ext),
    .div_sel_o   (div_sel),
    .busy_o      (busy),
    .irq_o       (irq_o),
    .data_o      (data_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/linesr_chk.sv
module linesr_chk #(
  parameter int CNT_W = 9,
  parameter int DEPTH = 320
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             send_i,
  input logic [CNT_W-1:0] word_cnt_i,
  input logic             ext_i,
  input logic             clk_en_i,
  input logic             busy_o,
  input logic             irq_o,
  input logic             data_o,
  input logic             ser_clk_o
);
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!data_o && !ser_clk_o));

  assert_done_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_o);

  assert_irq_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && irq_o));

  assert_edge_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !ext_i && !$stable(data_o)) |-> $fell(ser_clk_o));

  assert_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !ext_i && !$past(clk_en_i))
      |-> ($stable(ser_clk_o) && $stable(data_o)));

  assert_req_clk_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ext_i) |-> !ser_clk_o);

  assert_capacity_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_cnt_i <= CNT_W'(DEPTH));

  assert_empty_send_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && send_i && (word_cnt_i == '0)) |=> !busy_o);
endmodule

bind line_serializer linesr_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .send_i     (send_i),
  .word_cnt_i (word_cnt),
  .ext_i      (cfg_ext),
  .clk_en_i   (clk_en_i),
  .busy_o     (busy_o),
  .irq_o      (irq_o),
  .data_o     (data_o),
  .ser_clk_o  (ser_clk_o)
);

// File: tb/sim_line_serializer.sv
module sim_line_serializer;
  localparam int DEP = 320;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        line_start = 0, wr_en = 0, send = 0;
  logic [15:0] wr_data = '0;
  logic        c_lifo = 0, c_lsb = 0, c_pen = 0, c_plvl = 0, c_ext = 0;
  logic [7:0]  c_plen = '0;
  logic [2:0]  c_sel = '0;
  logic        clk_en = 1'b1, req = 1'b0;
  logic        ser_clk, dout, busy, irq;

  line_serializer u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .send_i(send), .cfg_lifo_i(c_lifo),
    .cfg_lsb_first_i(c_lsb), .cfg_pfx_en_i(c_pen), .cfg_pfx_level_i(c_plvl),
    .cfg_pfx_len_i(c_plen), .cfg_ext_clk_i(c_ext), .cfg_div_sel_i(c_sel),
    .clk_en_i(clk_en), .req_clk_i(req), .ser_clk_o(ser_clk), .data_o(dout),
    .busy_o(busy), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] model [DEP];
  int model_n = 0;
  bit got [8192];
  int got_n, gap_bad, sc_seen;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len();
    return (c_pen ? int'(c_plen) : 0) + 16 * model_n;
  endfunction

  function automatic bit exp_bit(int k);
    int p = c_pen ? int'(c_plen) : 0;
    int j, w, a, b;
    if (k < p) return c_plvl;
    j = k - p;
    w = j / 16;
    b = c_lsb ? (j % 16) : 15 - (j % 16);
    a = c_lifo ? model_n - 1 - w : w;
    return model[a][b];
  endfunction

  task automatic pulse_line_start();
    @(negedge clk) line_start = 1;
    @(negedge clk) line_start = 0;
  endtask

  task automatic write_line(int n, bit fixed, logic [15:0] w0, logic [15:0] w1, logic [15:0] w2);
    pulse_line_start();
    for (int i = 0; i < n; i++) begin
      logic [15:0] w;
      w = fixed ? ((i == 0) ? w0 : (i == 1) ? w1 : w2) : 16'($urandom);
      @(negedge clk) begin wr_en = 1; wr_data = w; end
      if (i < DEP) model[i] = w;
    end
    @(negedge clk) wr_en = 0;
    model_n = (n < DEP) ? n : DEP;
  endtask

  task automatic send_collect(bit rand_en);
    bit prev_sc = 0;
    int last_rise = -1;
    @(negedge clk) send = 1;
    @(negedge clk) send = 0;
    got_n = 0; gap_bad = 0; sc_seen = 0;
    if (!c_ext) begin
      while (busy) begin
        clk_en = rand_en ? (($urandom % 4) != 0) : 1'b1;
        if (ser_clk && !prev_sc) begin
          if (got_n < 8192) got[got_n] = dout;
          got_n++;
          if (!rand_en && last_rise >= 0 && (cyc - last_rise) != (2 << c_sel)) gap_bad++;
          last_rise = cyc;
        end
        prev_sc = ser_clk;
        @(negedge clk);
      end
      clk_en = 1;
    end else begin
      while (busy) begin
        if (got_n < 8192) got[got_n] = dout;
        got_n++;
        req = 1;
        repeat (3) begin @(negedge clk); if (ser_clk) sc_seen++; end
        req = 0;
        repeat (3) begin @(negedge clk); if (ser_clk) sc_seen++; end
      end
    end
  endtask

  task automatic check_stream(string req_tag);
    int bad = -1;
    check(got_n == exp_len(), req_tag, "bit count", got_n, exp_len());
    for (int k = 0; k < got_n && k < exp_len() && k < 8192; k++)
      if (got[k] != exp_bit(k)) begin bad = k; break; end
    check(bad < 0, req_tag, $sformatf("stream bit %0d", bad),
          (bad < 0) ? 0 : int'(got[bad]), (bad < 0) ? 0 : int'(exp_bit(bad)));
    check(irq && !busy, "R6", "irq/busy at end", {30'd0, irq, busy}, 2);
  endtask

  task automatic set_cfg(bit lifo, bit lsb, bit pen, bit plvl, int plen, bit ext, int sel);
    c_lifo = lifo; c_lsb = lsb; c_pen = pen; c_plvl = plvl;
    c_plen = 8'(plen); c_ext = ext; c_sel = 3'(sel);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, irq, dout, ser_clk} == 4'b0, "R1", "outputs in reset",
          {28'd0, busy, irq, dout, ser_clk}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check({busy, irq, dout, ser_clk} == 4'b0, "R1", "outputs after reset",
          {28'd0, busy, irq, dout, ser_clk}, 0);

    // R2, R4 (MSB first), R7 period at divide 1
    write_line(3, 1, 16'hA5C3, 16'h0001, 16'h8000);
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    send_collect(0);
    check_stream("R2");
    check(gap_bad == 0, "R7", "ser_clk period sel0", gap_bad, 0);

    // R3 reverse word order
    set_cfg(1, 0, 0, 0, 0, 0, 1);
    send_collect(0);
    check_stream("R3");
    check(gap_bad == 0, "R7", "ser_clk period sel1", gap_bad, 0);

    // R4 LSB first, divide 4
    set_cfg(0, 1, 0, 0, 0, 0, 2);
    send_collect(0);
    check_stream("R4");
    check(gap_bad == 0, "R7", "ser_clk period sel2", gap_bad, 0);

    // R5 prefix high, LIFO; prefix low, LSB; zero-length prefix
    set_cfg(1, 0, 1, 1, 5, 0, 0);
    send_collect(0);
    check_stream("R5");
    set_cfg(0, 1, 1, 0, 13, 0, 3);
    send_collect(0);
    check_stream("R5");
    check(gap_bad == 0, "R7", "ser_clk period sel3", gap_bad, 0);
    set_cfg(0, 0, 1, 1, 0, 0, 0);
    send_collect(0);
    check_stream("R5");

    // R6 irq cleared by line start
    pulse_line_start();
    @(negedge clk);
    check(irq == 0, "R6", "irq after line start", int'(irq), 0);

    // R12 empty send
    send = 1; @(negedge clk) send = 0;
    repeat (4) @(negedge clk);
    check(busy == 0 && dout == 0, "R12", "send with no words", int'(busy), 0);
    model_n = 0;

    // R9 request-clock mode with prefix
    write_line(2, 0, '0, '0, '0);
    set_cfg(0, 0, 1, 1, 3, 1, 4);
    send_collect(0);
    check_stream("R9");
    check(sc_seen == 0, "R9", "ser_clk idle in request mode", sc_seen, 0);

    // R8 freeze with clk_en low
    begin
      logic sd, ss;
      set_cfg(0, 0, 0, 0, 0, 0, 1);
      @(negedge clk) send = 1;
      @(negedge clk) send = 0;
      repeat (7) @(negedge clk);
      clk_en = 0;
      @(negedge clk);
      sd = dout; ss = ser_clk;
      gap_bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (dout != sd || ser_clk != ss || !busy) gap_bad++;
      end
      check(gap_bad == 0, "R8", "outputs frozen", gap_bad, 0);
      clk_en = 1;
      while (busy) @(negedge clk);
      check(irq == 1, "R8", "line completes after resume", int'(irq), 1);
    end

    // R12 writes/line start ignored while busy, then R10 repeat
    set_cfg(1, 1, 1, 0, 4, 0, 0);
    @(negedge clk) send = 1;
    @(negedge clk) send = 0;
    @(negedge clk) line_start = 1;
    @(negedge clk) begin line_start = 0; wr_en = 1; wr_data = 16'h1234; end
    @(negedge clk) wr_data = 16'hFFFF;
    @(negedge clk) wr_en = 0;
    while (busy) @(negedge clk);
    send_collect(0);
    check_stream("R10");
    check_stream("R12");

    // R10 random clk_en pauses still give the same line
    send_collect(1);
    check_stream("R10");

    // R11 capacity
    write_line(330, 0, '0, '0, '0);
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    send_collect(0);
    check_stream("R11");
    check(got_n == 5120, "R11", "full line bits", got_n, 5120);

    // random lines
    for (int r = 0; r < 10; r++) begin
      bit pen;
      write_line(1 + int'($urandom % 8), 0, '0, '0, '0);
      pen = ($urandom % 2) != 0;
      set_cfg(($urandom % 2) != 0, ($urandom % 2) != 0, pen, ($urandom % 2) != 0,
              int'($urandom % 24), ($urandom % 4) == 0, int'($urandom % 5));
      send_collect(($urandom % 3) == 0);
      check_stream(c_lifo ? "R3" : "R2");
      check_stream("R10");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule